// File: doc/BRIEF.md
# Coprocessor Cycle Timer and Interrupt Acceptance Gate

This block holds the cycle counter and compare register of a system coprocessor and decides, every cycle, whether the core should accept a hardware interrupt. The counter advances by one on each clock, including clocks the core spends idle. When the counter reaches the compare value, a timer request latches into the top pending bit. It stays there until software writes the compare register again.

Five external request lines are sampled each cycle into the next five pending bits. Two software-owned pending bits sit below them. A software write can set those two bits, but they never cause acceptance here. The core supplies the status fields: global enable, exception level, error level and an eight-bit mask. Acceptance needs the global enable set, both level flags clear, and at least one of the six hardware pending bits unmasked. On acceptance the block gives a one-cycle take pulse with the interrupt exception code. It also gives a wake signal if the core was idle, and it records whether the interrupted instruction sat in a branch delay slot. While the core is idle and nothing is taken, the fetch enable stays low.

Top module: `cop_timer_irq`

## Requirements
- R1: While `rst_n` is low, `count_o` and `cause_ip_o` are zero and `take_irq_o` is 0.
- R2: `count_o` increases by one on every clock edge without a count write, also while `waiting_i` is 1. It wraps from all ones to zero.
- R3: With `wr_en_i` = 1, `wr_sel_i` = 0 loads `count_o` from `wr_data_i` at the next edge. `wr_sel_i` = 1 loads the compare register. `wr_sel_i` = 2 loads the software pending bits.
- R4: `cause_ip_o[7]` (timer request) becomes 1 at the edge where the counter's new value equals the compare value. It stays 1 until the edge that performs a compare write, which clears it.
- R5: `cause_ip_o[6:2]` equals `ext_irq_i[4:0]` as sampled at the previous clock edge.
- R6: A software-pending write copies `wr_data_i[9:8]` to `cause_ip_o[1:0]`. Those bits never produce `take_irq_o`, even when their mask bits are 1.
- R7: `take_irq_o` is 0 whenever `st_ie_i` is 0, `st_exl_i` is 1 or `st_erl_i` is 1.
- R8: An interrupt is pending when `cause_ip_o[7:2] & st_mask_i[7:2]` is nonzero. `take_irq_o` needs a pending interrupt.
- R9: `take_irq_o` is a one-cycle pulse in the first cycle the accept condition holds. It fires again only after the condition has been false for at least one cycle. With it, `exc_code_o` reads 0 (interrupt).
- R10: `wake_o` is 1 exactly when `take_irq_o` is 1 and `waiting_i` is 1.
- R11: At the edge ending a take cycle, `irq_in_delay_o` captures `in_delay_i`. It holds that value until the next take.
- R12: `fetch_o` is 1 only when `waiting_i` is 0 and `take_irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| ext_irq_i | input | 5 | External interrupt request lines |
| st_ie_i | input | 1 | Status global interrupt enable |
| st_exl_i | input | 1 | Status exception level |
| st_erl_i | input | 1 | Status error level |
| st_mask_i | input | 8 | Status interrupt mask for pending bits 7:0 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 count, 1 compare, 2 software pending |
| wr_data_i | input | 32 | Write data |
| waiting_i | input | 1 | Core is idle waiting for an interrupt |
| in_delay_i | input | 1 | Current instruction is in a branch delay slot |
| take_irq_o | output | 1 | Interrupt accepted this cycle (pulse) |
| exc_code_o | output | 5 | Exception code for the accepted interrupt |
| cause_ip_o | output | 8 | Pending bits (Cause 15:8 positions) |
| wake_o | output | 1 | Clear the core's waiting state |
| fetch_o | output | 1 | Instruction fetch allowed this cycle |
| irq_in_delay_o | output | 1 | Delay-slot flag of the last interrupted instruction |
| count_o | output | 32 | Current counter value |

## Verification
Acceptance is tried with the timer request, an external line and the software bits each used as the only pending source. This separates the hardware-bit window from the software bits and shows the mask applied per bit. Each gating field (enable, exception level, error level) is switched one at a time with a live pending source, so each blocks acceptance on its own. The counter is preset just below the compare value to time the exact match edge, and preset to all ones to see the wrap. Holding, dropping and re-raising the enable shows the pulse shape and its re-arming. The idle and delay-slot inputs are varied around takes to separate wake, fetch and capture.

// File: rtl/cop_timer_pkg.sv
package cop_timer_pkg;
  localparam int unsigned EXC_W = 5;
  localparam logic [EXC_W-1:0] EXC_INTERRUPT = '0;

  typedef enum logic [1:0] {
    WSEL_COUNT   = 2'd0,
    WSEL_COMPARE = 2'd1,
    WSEL_SOFT    = 2'd2,
    WSEL_NONE    = 2'd3
  } wsel_e;
endpackage

// File: rtl/cop_tick_counter.sv
module cop_tick_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_we,
  input  logic              cmp_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count_o,
  output logic              timer_req_o
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] cmp_q, cmp_d;
  logic              req_q, req_d;
  logic              hit;

  always_comb begin
    cnt_d = cnt_we ? wdata : cnt_q + DATA_W'(1);
    cmp_d = cmp_we ? wdata : cmp_q;
    hit   = (cnt_d == cmp_q);
    if (cmp_we)   req_d = 1'b0;
    else if (hit) req_d = 1'b1;
    else          req_d = req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (cmp_we) cmp_q <= cmp_d;
      req_q <= req_d;
    end
  end

  assign count_o     = cnt_q;
  assign timer_req_o = req_q;
endmodule

// File: rtl/cop_pending_bits.sv
module cop_pending_bits #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_EXT  = 5,
  parameter int unsigned N_SW   = 2,
  parameter int unsigned SW_LSB = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_EXT-1:0]       ext_irq,
  input  logic                   sw_we,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   timer_req,
  output logic [N_EXT+N_SW:0]    ip_o
);
  logic [N_EXT-1:0] ext_q, ext_d;
  logic [N_SW-1:0]  sw_q, sw_d;

  always_comb begin
    ext_d = ext_irq;
    sw_d  = sw_we ? wdata[SW_LSB +: N_SW] : sw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '0;
      sw_q  <= '0;
    end else begin
      ext_q <= ext_d;
      if (sw_we) sw_q <= sw_d;
    end
  end

  assign ip_o = {timer_req, ext_q, sw_q};
endmodule

// File: rtl/cop_accept_gate.sv
module cop_accept_gate
  import cop_timer_pkg::*;
#(
  parameter int unsigned N_HW = 6,
  parameter int unsigned N_SW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_HW+N_SW-1:0] ip,
  input  logic [N_HW+N_SW-1:0] mask,
  input  logic                 ie,
  input  logic                 exl,
  input  logic                 erl,
  input  logic                 waiting,
  input  logic                 in_delay,
  output logic                 take_o,
  output logic [EXC_W-1:0]     exc_code_o,
  output logic                 wake_o,
  output logic                 fetch_o,
  output logic                 dly_o
);
  localparam int unsigned IP_W = N_HW + N_SW;

  logic [N_HW-1:0] hw_live;
  logic            enabled;
  logic            accept;
  logic            armed_q, armed_d;
  logic            dly_q, dly_d;

  always_comb begin
    hw_live = ip[IP_W-1:N_SW] & mask[IP_W-1:N_SW];
    enabled = ie & ~exl & ~erl;
    accept  = enabled & (|hw_live);
    take_o  = accept & ~armed_q;
    armed_d = accept;
    dly_d   = take_o ? in_delay : dly_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      dly_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      if (take_o) dly_q <= dly_d;
    end
  end

  assign exc_code_o = take_o ? EXC_INTERRUPT : '0;
  assign wake_o     = take_o & waiting;
  assign fetch_o    = ~take_o & ~waiting;
  assign dly_o      = dly_q;
endmodule

// File: rtl/cop_timer_irq.sv
module cop_timer_irq
  import cop_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_HW   = 6,
  parameter int unsigned N_SW   = 2,
  parameter int unsigned SW_LSB = 8,
  localparam int unsigned N_EXT = N_HW - 1,
  localparam int unsigned IP_W  = N_HW + N_SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_irq_i,
  input  logic              st_ie_i,
  input  logic              st_exl_i,
  input  logic              st_erl_i,
  input  logic [IP_W-1:0]   st_mask_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              waiting_i,
  input  logic              in_delay_i,
  output logic              take_irq_o,
  output logic [EXC_W-1:0]  exc_code_o,
  output logic [IP_W-1:0]   cause_ip_o,
  output logic              wake_o,
  output logic              fetch_o,
  output logic              irq_in_delay_o,
  output logic [DATA_W-1:0] count_o
);
  wsel_e sel;
  logic  cnt_we, cmp_we, sw_we;
  logic  timer_req;

  always_comb begin
    sel    = wsel_e'(wr_sel_i);
    cnt_we = wr_en_i & (sel == WSEL_COUNT);
    cmp_we = wr_en_i & (sel == WSEL_COMPARE);
    sw_we  = wr_en_i & (sel == WSEL_SOFT);
  end

  cop_tick_counter #(.DATA_W(DATA_W)) u_tick (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_we      (cnt_we),
    .cmp_we      (cmp_we),
    .wdata       (wr_data_i),
    .count_o     (count_o),
    .timer_req_o (timer_req)
  );

  cop_pending_bits #(
    .DATA_W (DATA_W),
    .N_EXT  (N_EXT),
    .N_SW   (N_SW),
    .SW_LSB (SW_LSB)
  ) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_irq   (ext_irq_i),
    .sw_we     (sw_we),
    .wdata     (wr_data_i),
    .timer_req (timer_req),
    .ip_o      (cause_ip_o)
  );

  cop_accept_gate #(.N_HW(N_HW), .N_SW(N_SW)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .ip         (cause_ip_o),
    .mask       (st_mask_i),
    .ie         (st_ie_i),
    .exl        (st_exl_i),
    .erl        (st_erl_i),
    .waiting    (waiting_i),
    .in_delay   (in_delay_i),
    .take_o     (take_irq_o),
    .exc_code_o (exc_code_o),
    .wake_o     (wake_o),
    .fetch_o    (fetch_o),
    .dly_o      (irq_in_delay_o)
  );
endmodule

// File: rtl/cop_timer_irq_chk.sv
module cop_timer_irq_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_EXT  = 5,
  parameter int unsigned IP_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_EXT-1:0]  ext_irq_i,
  input logic              st_ie_i,
  input logic              st_exl_i,
  input logic              st_erl_i,
  input logic [IP_W-1:0]   st_mask_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic              waiting_i,
  input logic              in_delay_i,
  input logic              take_irq_o,
  input logic [IP_W-1:0]   cause_ip_o,
  input logic              wake_o,
  input logic              fetch_o,
  input logic              irq_in_delay_o,
  input logic [DATA_W-1:0] count_o
);
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_sel_i == 2'd0) |=> count_o == $past(count_o) + DATA_W'(1));

  a_r4_compare_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd1) |=> !cause_ip_o[IP_W-1]);

  a_r5_ext_sampled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cause_ip_o[IP_W-2:IP_W-1-N_EXT] == $past(ext_irq_i));

  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |-> (st_ie_i && !st_exl_i && !st_erl_i));

  a_r8_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |-> |(cause_ip_o[IP_W-1:IP_W-1-N_EXT] & st_mask_i[IP_W-1:IP_W-1-N_EXT]));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |=> !take_irq_o);

  a_r10_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (take_irq_o && waiting_i));

  a_r11_capture: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq_o |=> irq_in_delay_o == $past(in_delay_i));

  a_r12_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |-> (!waiting_i && !take_irq_o));
endmodule

bind cop_timer_irq cop_timer_irq_chk #(
  .DATA_W (DATA_W),
  .N_EXT  (N_EXT),
  .IP_W   (IP_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ext_irq_i      (ext_irq_i),
  .st_ie_i        (st_ie_i),
  .st_exl_i       (st_exl_i),
  .st_erl_i       (st_erl_i),
  .st_mask_i      (st_mask_i),
  .wr_en_i        (wr_en_i),
  .wr_sel_i       (wr_sel_i),
  .waiting_i      (waiting_i),
  .in_delay_i     (in_delay_i),
  .take_irq_o     (take_irq_o),
  .cause_ip_o     (cause_ip_o),
  .wake_o         (wake_o),
  .fetch_o        (fetch_o),
  .irq_in_delay_o (irq_in_delay_o),
  .count_o        (count_o)
);

// File: tb/cop_timer_irq_test.sv
module cop_timer_irq_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  ext_irq;
  logic        ie, exl, erl;
  logic [7:0]  mask;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        waiting, in_delay;
  logic        take;
  logic [4:0]  exc_code;
  logic [7:0]  ip;
  logic        wake, fetch, dly;
  logic [31:0] count;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_timer_irq uut (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .st_ie_i(ie),
    .st_exl_i(exl), .st_erl_i(erl), .st_mask_i(mask), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .waiting_i(waiting),
    .in_delay_i(in_delay), .take_irq_o(take), .exc_code_o(exc_code),
    .cause_ip_o(ip), .wake_o(wake), .fetch_o(fetch),
    .irq_in_delay_o(dly), .count_o(count)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle_all();
    @(negedge clk);
    ext_irq = '0; ie = 0; exl = 0; erl = 0; mask = '0;
    waiting = 0; in_delay = 0; wr_en = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    eq("R1 count in reset", count, 0);
    eq("R1 pending in reset", {24'b0, ip}, 0);
    eq("R1 take in reset", {31'b0, take}, 0);
  endtask

  task automatic t_count();
    logic [31:0] c0;
    @(negedge clk); waiting = 1'b1;
    c0 = count;
    edges(7);
    eq("R2 count steps while waiting", count, c0 + 7);
    wr(2'd0, 32'hFFFF_FFFE);
    eq("R3 count load", count, 32'hFFFF_FFFE);
    edges(2);
    eq("R2 count wraps to zero", count, 0);
    @(negedge clk); waiting = 1'b0;
  endtask

  task automatic t_timer();
    wr(2'd1, 32'd50);
    wr(2'd0, 32'd47);
    eq("R3 count preset", count, 47);
    eq("R4 no request before match", {31'b0, ip[7]}, 0);
    edges(2);
    eq("R4 no request at count 49", {31'b0, ip[7]}, 0);
    edges(1);
    eq("R4 request at match", {31'b0, ip[7]}, 1);
    edges(4);
    eq("R4 request stays", {31'b0, ip[7]}, 1);
    @(negedge clk); waiting = 1; mask = 8'h80; ie = 1;
    #1;
    eq("R10 timer wakes idle core", {31'b0, wake}, 1);
    eq("R12 no fetch on take", {31'b0, fetch}, 0);
    @(negedge clk); ie = 0; waiting = 0; mask = 0;
    wr(2'd1, 32'd100000);
    eq("R4 compare write clears", {31'b0, ip[7]}, 0);
  endtask

  task automatic t_ext();
    @(negedge clk); ext_irq = 5'b10101;
    #1;
    eq("R5 not yet sampled", {27'b0, ip[6:2]}, 0);
    edges(1);
    eq("R5 sampled lines", {27'b0, ip[6:2]}, 5'b10101);
    @(negedge clk); ext_irq = 5'b00010;
    edges(1);
    eq("R5 second pattern", {27'b0, ip[6:2]}, 5'b00010);
    @(negedge clk); ext_irq = 0;
    edges(1);
  endtask

  task automatic t_soft();
    wr(2'd2, 32'h0000_0300);
    eq("R6 soft bits set", {30'b0, ip[1:0]}, 2'b11);
    @(negedge clk); mask = 8'hFF; ie = 1;
    #1;
    eq("R6 soft bits never take", {31'b0, take}, 0);
    @(negedge clk); mask = 0; ie = 0;
    wr(2'd2, 32'h0000_0100);
    eq("R6 soft bits rewritten", {30'b0, ip[1:0]}, 2'b01);
    wr(2'd2, 0);
  endtask

  task automatic t_gate();
    @(negedge clk); ext_irq = 5'b00001; mask = 8'h04;
    @(negedge clk);
    ie = 0; #1;
    eq("R7 blocked by enable off", {31'b0, take}, 0);
    @(negedge clk); ie = 1; exl = 1; #1;
    eq("R7 blocked by exception level", {31'b0, take}, 0);
    @(negedge clk); exl = 0; erl = 1; #1;
    eq("R7 blocked by error level", {31'b0, take}, 0);
    @(negedge clk); erl = 0; mask = 8'h08; #1;
    eq("R8 other bit masked", {31'b0, take}, 0);
    @(negedge clk); mask = 8'h04; #1;
    eq("R8 unmasked pending takes", {31'b0, take}, 1);
    eq("R9 interrupt code", {27'b0, exc_code}, 0);
    idle_all();
  endtask

  task automatic t_pulse();
    @(negedge clk); ext_irq = 5'b01000; mask = 8'h20;
    @(negedge clk); ie = 1; #1;
    eq("R9 first cycle takes", {31'b0, take}, 1);
    edges(1);
    eq("R9 pulse ends", {31'b0, take}, 0);
    edges(3);
    eq("R9 no repeat while held", {31'b0, take}, 0);
    @(negedge clk); ie = 0;
    @(negedge clk); ie = 1; #1;
    eq("R9 rearmed after drop", {31'b0, take}, 1);
    eq("R10 no wake when active", {31'b0, wake}, 0);
    idle_all();
  endtask

  task automatic t_delay_fetch();
    @(negedge clk); ext_irq = 5'b00001; mask = 8'h04; in_delay = 1;
    @(negedge clk); ie = 1;
    edges(1);
    eq("R11 delay flag captured", {31'b0, dly}, 1);
    @(negedge clk); in_delay = 0; #1;
    eq("R11 held without take", {31'b0, dly}, 1);
    @(negedge clk); ie = 0;
    @(negedge clk); ie = 1;
    edges(1);
    eq("R11 cleared by next take", {31'b0, dly}, 0);
    idle_all();
    @(negedge clk); waiting = 1; #1;
    eq("R12 no fetch while idle", {31'b0, fetch}, 0);
    eq("R10 no wake without take", {31'b0, wake}, 0);
    @(negedge clk); waiting = 0; #1;
    eq("R12 fetch when running", {31'b0, fetch}, 1);
  endtask

  initial begin
    rst_n = 0; ext_irq = 0; ie = 0; exl = 0; erl = 0; mask = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0; waiting = 0; in_delay = 0;
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_count();
    t_timer();
    t_ext();
    t_soft();
    t_gate();
    t_pulse();
    t_delay_fetch();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule